// File: doc/BRIEF.md
# Delay-Slot Illegal Instruction Detector

This block sits in the decode stage of a processor with 16-bit instructions and delayed branches. For every decoded instruction it decides whether the instruction is legal, a general illegal instruction, or an illegal slot instruction, and it raises the matching exception strobe. Whether an instruction is legal depends on its position. An instruction that writes the program counter is legal in normal flow. The same instruction is illegal when it sits in the delay slot behind a delayed branch.

The pipeline supplies the opcode, a decode-valid strobe and an input that says the current instruction sits in a delay slot. The block returns two exception strobes and a registered flag. The flag tells the pipeline that the next valid instruction is a delay-slot instruction. The pipeline normally feeds that flag back to the slot input.

Opcodes are matched against a fixed table of pattern/mask forms that is computed in a package. An opcode that matches no form counts as undefined. A parameter selects whether the strobes leave the block combinationally in the decode cycle or through a register one cycle later.

Top module: `dsi_detector`

## Requirements
- R1: When `dec_valid`=1, `in_slot`=0 and the opcode matches no defined form (for example 16'hFFFF, 16'h0000, 16'h4A2C), `exc_general`=1 and `exc_slot`=0 in that decode cycle.
- R2: When `dec_valid`=1, `in_slot`=1 and the opcode is undefined, `exc_slot`=1 and `exc_general`=0.
- R3: When `dec_valid`=1 and `in_slot`=1, every program-counter-writing form raises `exc_slot`=1 with `exc_general`=0. The forms are written as (pattern/mask) and an opcode matches when (op & mask)==pattern. The delayed branches are: register jump 16'h402B/16'hF0FF, register call 16'h400B/16'hF0FF, relative branch 16'hA000/16'hF000, relative call 16'hB000/16'hF000, return 16'h000B/16'hFFFF, exception return 16'h002B/16'hFFFF, branch-if-true delayed 16'h8D00/16'hFF00, branch-if-false delayed 16'h8F00/16'hFF00, register-relative branch 16'h0023/16'hF0FF and register-relative call 16'h0003/16'hF0FF. The non-delayed writers are: branch-if-true 16'h8900/16'hFF00, branch-if-false 16'h8B00/16'hFF00 and trap 16'hC300/16'hFF00.
- R4: When `in_slot`=0, every form listed in R3 and every plain form raises no exception. The plain forms are no-op 16'h0009/16'hFFFF, register move 16'h6003/16'hF00F, add immediate 16'h7000/16'hF000 and load immediate 16'hE000/16'hF000.
- R5: A plain form with `in_slot`=1 raises no exception.
- R6: A valid, non-excepting delayed branch sets `slot_flag` to 1 at the next clock edge. A valid branch-if-true, branch-if-false or trap leaves it at 0.
- R7: Once set, `slot_flag` holds while `dec_valid`=0. It clears at the edge that ends the next valid decode.
- R8: `slot_flag` is 0 during and after reset. It clears at the edge that ends any decode that raises an exception.
- R9: A delayed branch that is itself in a slot raises `exc_slot` and does not set `slot_flag`.
- R10: At most one exception strobe is high in any cycle. Both strobes are low whenever `dec_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is present this cycle |
| opcode | input | 16 | Instruction word |
| in_slot | input | 1 | Current instruction sits in a delay slot |
| exc_general | output | 1 | General illegal instruction request |
| exc_slot | output | 1 | Illegal slot instruction request |
| slot_flag | output | 1 | Next valid instruction is a delay-slot instruction |

## Verification
The bound checker assumes that `dec_valid`, `in_slot` and `opcode` are known and stable around each rising edge once reset is released. With the default combinational strobes, it also relates the strobes to the inputs of the same cycle. The bench meets these assumptions by changing every input only on the falling edge. It separates each decode with an idle cycle, which also exercises the hold behaviour of `slot_flag`. The bench drives `in_slot` directly rather than looping `slot_flag` back, so that slot and non-slot cases can be chosen freely for every opcode.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
   localparam int OP_W    = 16;
   localparam int N_FORMS = 17;

   typedef struct packed {
      logic [OP_W-1:0] pat;
      logic [OP_W-1:0] mask;
      logic            dbr;   // delayed branch: makes next one a slot
      logic            pcw;   // writes the program counter
   } form_t;

   function automatic form_t form_at(input int i);
      form_t f;
      case (i)
         0:  f = '{16'h402B, 16'hF0FF, 1'b1, 1'b1}; // register jump
         1:  f = '{16'h400B, 16'hF0FF, 1'b1, 1'b1}; // register call
         2:  f = '{16'hA000, 16'hF000, 1'b1, 1'b1}; // relative branch
         3:  f = '{16'hB000, 16'hF000, 1'b1, 1'b1}; // relative call
         4:  f = '{16'h000B, 16'hFFFF, 1'b1, 1'b1}; // return
         5:  f = '{16'h002B, 16'hFFFF, 1'b1, 1'b1}; // exception return
         6:  f = '{16'h8D00, 16'hFF00, 1'b1, 1'b1}; // if-true delayed
         7:  f = '{16'h8F00, 16'hFF00, 1'b1, 1'b1}; // if-false delayed
         8:  f = '{16'h0023, 16'hF0FF, 1'b1, 1'b1}; // reg-relative branch
         9:  f = '{16'h0003, 16'hF0FF, 1'b1, 1'b1}; // reg-relative call
         10: f = '{16'h8900, 16'hFF00, 1'b0, 1'b1}; // if-true
         11: f = '{16'h8B00, 16'hFF00, 1'b0, 1'b1}; // if-false
         12: f = '{16'hC300, 16'hFF00, 1'b0, 1'b1}; // trap
         13: f = '{16'h0009, 16'hFFFF, 1'b0, 1'b0}; // no-op
         14: f = '{16'h6003, 16'hF00F, 1'b0, 1'b0}; // register move
         15: f = '{16'h7000, 16'hF000, 1'b0, 1'b0}; // add immediate
         default: f = '{16'hE000, 16'hF000, 1'b0, 1'b0}; // load immediate
      endcase
      return f;
   endfunction

   function automatic logic [N_FORMS-1:0] dbr_vec();
      logic [N_FORMS-1:0] v;
      for (int i = 0; i < N_FORMS; i++) v[i] = form_at(i).dbr;
      return v;
   endfunction

   function automatic logic [N_FORMS-1:0] pcw_vec();
      logic [N_FORMS-1:0] v;
      for (int i = 0; i < N_FORMS; i++) v[i] = form_at(i).pcw;
      return v;
   endfunction
endpackage

// File: rtl/dsi_match.sv
module dsi_match
   import dsi_pkg::*;
#(
   parameter int W = OP_W,
   parameter int N = N_FORMS
) (
   input  logic [W-1:0] op,
   output logic         defined,
   output logic         is_dbr,
   output logic         is_pcw
);
   localparam logic [N-1:0] DBR_V = dbr_vec();
   localparam logic [N-1:0] PCW_V = pcw_vec();

   if (W != OP_W) begin : g_bad_w
      $error("dsi_match: table is built for %0d-bit opcodes", OP_W);
   end
   if (N != N_FORMS) begin : g_bad_n
      $error("dsi_match: form count must equal the table size");
   end

   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_form
      localparam form_t F = form_at(i);
      assign hit[i] = ((op & F.mask) == F.pat);
   end

   assign defined = |hit;
   assign is_dbr  = |(hit & DBR_V);
   assign is_pcw  = |(hit & PCW_V);
endmodule

// File: rtl/dsi_classify.sv
module dsi_classify (
   input  logic valid,
   input  logic slot,
   input  logic defined,
   input  logic is_pcw,
   output logic gen_ill,
   output logic slot_ill
);
   always_comb begin
      gen_ill  = 1'b0;
      slot_ill = 1'b0;
      if (valid) begin
         if (slot) slot_ill = !defined || is_pcw;
         else      gen_ill  = !defined;
      end
   end
endmodule

// File: rtl/dsi_slot_flag.sv
module dsi_slot_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic is_dbr,
   input  logic any_exc,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (any_exc) flag <= 1'b0;
      else if (valid)   flag <= is_dbr;
   end
endmodule

// File: rtl/dsi_detector.sv
module dsi_detector #(
   parameter int OPW     = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dec_valid,
   input  logic [OPW-1:0] opcode,
   input  logic           in_slot,
   output logic           exc_general,
   output logic           exc_slot,
   output logic           slot_flag
);
   logic defined, is_dbr, is_pcw;
   logic gen_ill, slot_ill;

   dsi_match #(.W(OPW)) u_match (
      .op(opcode), .defined(defined), .is_dbr(is_dbr), .is_pcw(is_pcw)
   );

   dsi_classify u_cls (
      .valid(dec_valid), .slot(in_slot), .defined(defined),
      .is_pcw(is_pcw), .gen_ill(gen_ill), .slot_ill(slot_ill)
   );

   dsi_slot_flag u_flag (
      .clk(clk), .rst_n(rst_n), .valid(dec_valid), .is_dbr(is_dbr),
      .any_exc(gen_ill || slot_ill), .flag(slot_flag)
   );

   if (REG_OUT) begin : g_reg
      logic g_q, s_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            g_q <= 1'b0;
            s_q <= 1'b0;
         end else begin
            g_q <= gen_ill;
            s_q <= slot_ill;
         end
      end
      assign exc_general = g_q;
      assign exc_slot    = s_q;
   end else begin : g_comb
      assign exc_general = gen_ill;
      assign exc_slot    = slot_ill;
   end
endmodule

// File: rtl/dsi_checker.sv
module dsi_checker #(
   parameter bit REG_OUT = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic dec_valid,
   input logic in_slot,
   input logic exc_general,
   input logic exc_slot,
   input logic slot_flag
);
   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_general, exc_slot}));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> $stable(slot_flag));

   p_slot_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && in_slot) |=> !slot_flag);

   if (!REG_OUT) begin : g_comb_chk
      p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_valid |-> (!exc_general && !exc_slot));
      p_gen_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
         exc_general |-> !in_slot);
      p_slot_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
         exc_slot |-> in_slot);
      p_exc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (exc_general || exc_slot) |=> !slot_flag);
   end
endmodule

bind dsi_detector dsi_checker #(.REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .in_slot(in_slot),
   .exc_general(exc_general), .exc_slot(exc_slot), .slot_flag(slot_flag)
);

// File: tb/sim_dsi_detector.sv
module sim_dsi_detector;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dec_valid = 1'b0;
   logic [15:0] opcode = 16'h0;
   logic in_slot = 1'b0;
   logic exc_general, exc_slot, slot_flag;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dsi_detector u0 (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .opcode(opcode),
      .in_slot(in_slot), .exc_general(exc_general), .exc_slot(exc_slot),
      .slot_flag(slot_flag)
   );

   // independent opcode samples
   logic [15:0] dly_ops [10] = '{16'h4A2B, 16'h430B, 16'hA123, 16'hB7FF,
      16'h000B, 16'h002B, 16'h8D10, 16'h8F05, 16'h0323, 16'h0503};
   logic [15:0] nd_ops [3]   = '{16'h8910, 16'h8B22, 16'hC320};
   logic [15:0] plain_ops [4] = '{16'h0009, 16'h6123, 16'h7105, 16'hE2FF};
   logic [15:0] undef_ops [3] = '{16'hFFFF, 16'h0000, 16'h4A2C};

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one decode, then one idle cycle; returns strobes and the flag after the edge
   task automatic step(input logic v, input logic [15:0] op, input logic sl,
                       output logic g, output logic s, output logic f);
      @(negedge clk);
      dec_valid = v; opcode = op; in_slot = sl;
      #1; g = exc_general; s = exc_slot;
      @(negedge clk);
      f = slot_flag;
      dec_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R8 reset flag", {31'b0, slot_flag}, 0);
      chk("R10 reset strobes", {30'b0, exc_general, exc_slot}, 0);
   endtask

   task automatic t_general();
      logic g, s, f;
      foreach (undef_ops[i]) begin
         step(1'b1, undef_ops[i], 1'b0, g, s, f);
         chk("R1 undefined out of slot", {30'b0, g, s}, 32'h2);
      end
   endtask

   task automatic t_slot_undef();
      logic g, s, f;
      foreach (undef_ops[i]) begin
         step(1'b1, undef_ops[i], 1'b1, g, s, f);
         chk("R2 undefined in slot", {30'b0, g, s}, 32'h1);
      end
   endtask

   task automatic t_slot_pcw();
      logic g, s, f;
      foreach (dly_ops[i]) begin
         step(1'b1, dly_ops[i], 1'b1, g, s, f);
         chk("R3 delayed branch in slot", {30'b0, g, s}, 32'h1);
         chk("R9 no flag from slot branch", {31'b0, f}, 0);
      end
      foreach (nd_ops[i]) begin
         step(1'b1, nd_ops[i], 1'b1, g, s, f);
         chk("R3 pc writer in slot", {30'b0, g, s}, 32'h1);
      end
   endtask

   task automatic t_outside();
      logic g, s, f;
      foreach (dly_ops[i]) begin
         step(1'b1, dly_ops[i], 1'b0, g, s, f);
         chk("R4 delayed branch legal", {30'b0, g, s}, 0);
         chk("R6 flag set", {31'b0, f}, 1);
         step(1'b1, 16'h0009, 1'b1, g, s, f);   // clear via slot decode
         chk("R7 flag cleared", {31'b0, f}, 0);
      end
      foreach (nd_ops[i]) begin
         step(1'b1, nd_ops[i], 1'b0, g, s, f);
         chk("R4 pc writer legal", {30'b0, g, s}, 0);
         chk("R6 no flag from non-delayed", {31'b0, f}, 0);
      end
      foreach (plain_ops[i]) begin
         step(1'b1, plain_ops[i], 1'b0, g, s, f);
         chk("R4 plain legal", {30'b0, g, s}, 0);
      end
   endtask

   task automatic t_slot_plain();
      logic g, s, f;
      foreach (plain_ops[i]) begin
         step(1'b1, plain_ops[i], 1'b1, g, s, f);
         chk("R5 plain in slot", {30'b0, g, s}, 0);
      end
   endtask

   task automatic t_flag_life();
      logic g, s, f;
      step(1'b1, 16'hA010, 1'b0, g, s, f);
      chk("R6 set by branch", {31'b0, f}, 1);
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 16'hFFFF, 1'b1, g, s, f);
         chk("R7 hold while idle", {31'b0, f}, 1);
         chk("R10 idle no strobe", {30'b0, g, s}, 0);
      end
      step(1'b1, 16'h7105, 1'b1, g, s, f);
      chk("R7 clear after one decode", {31'b0, f}, 0);
   endtask

   task automatic t_exc_clear();
      logic g, s, f;
      step(1'b1, 16'hB001, 1'b0, g, s, f);
      chk("R6 set before exception", {31'b0, f}, 1);
      step(1'b1, 16'hFFFF, 1'b0, g, s, f);
      chk("R8 general strobe", {30'b0, g, s}, 32'h2);
      chk("R8 exception clears flag", {31'b0, f}, 0);
      step(1'b1, 16'h000B, 1'b0, g, s, f);
      chk("R6 set before reset", {31'b0, f}, 1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset clears flag", {31'b0, slot_flag}, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_general();
      t_slot_undef();
      t_slot_pcw();
      t_outside();
      t_slot_plain();
      t_flag_life();
      t_exc_clear();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule